// File: doc/BRIEF.md
# ADC Conversion Sequencer with Guarded Channel Selection

This block sequences the digital side of a successive-approximation converter. Software writes a channel number and a reference choice into a staging register at any time. The block copies the staged value into the active selection that drives the analog multiplexer, but only while that is safe. The active selection is frozen from the start of a conversion until the last converter-clock period before the conversion ends. When the converter is disabled, nothing is frozen.

The block runs on a clock at twice the converter rate, so every converter period is two clock edges. This allows timing points on half periods. The converter-clock phase begins at reset: the first edge after reset release is a rising converter edge, and so is every second edge after it. A conversion is started in one of three ways: by a software start strobe, by free-running restarts, or by a rising edge on an external trigger. Each conversion produces a one-clock sample-and-hold strobe. When it completes, the block raises a completion flag and captures the converter's output word. The conversion kind sets both the strobe position and the length.

Top module: `adc_seq_top`

## Requirements
- R1: While `rst` is high, and immediately after reset, `busy`, `done_flag`, `sh_strobe`, `result`, `act_chan` and `act_ref` are all zero.
- R2: A `cfg_wr` pulse loads the staging register on the next edge. While no conversion holds the selection, `act_chan`/`act_ref` take the staged value one edge later.
- R3: From its start edge T, a conversion of length L holds `act_chan`/`act_ref` stable. The selection updates again at edge T+L-1, which lies in the last converter period.
- R4: A `start_wr` pulse sampled at edge E while idle and enabled starts a conversion at the next rising converter edge after E: E+2 when E is even, E+1 when E is odd. `busy` reads one from edge E until completion, and drops with the completion unless free-running continues.
- R5: The first conversion after `en` rises (or after reset) lasts 50 edges, and `sh_strobe` is high after edge T+27.
- R6: A later conversion started by `start_wr` or by a free-running restart lasts 26 edges, with `sh_strobe` high after edge T+3.
- R7: With `en`, `auto_en` set and `trig_sel`=2'b10, a rising edge on `trig_in` while idle starts a conversion at the edge that detects it. That conversion lasts 27 edges, with the strobe after T+4. A trigger edge that arrives while busy is ignored.
- R8: With `auto_en` set and `trig_sel`=2'b01, a new 26-edge conversion starts at the same edge that completes the previous one. A selection written just after a completion therefore first appears in the conversion after the next one.
- R9: `done_flag` is set at the completion edge and stays set until a `flag_clr` pulse. If completion and clear fall on the same edge, the set wins.
- R10: `result` takes `conv_data` at the completion edge and holds it at all other times.
- R11: Dropping `en` aborts any conversion and any pending start, releases the selection, and makes the next conversion a 50-edge first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| auto_en | input | 1 | Enables automatic starts |
| trig_sel | input | 2 | Automatic source: 2'b01 free running, 2'b10 external trigger |
| cfg_wr | input | 1 | Staging register write strobe |
| cfg_chan | input | 4 | Channel to stage |
| cfg_ref | input | 3 | Reference to stage |
| start_wr | input | 1 | Software start strobe |
| trig_in | input | 1 | External trigger level |
| flag_clr | input | 1 | Clears the completion flag |
| conv_data | input | 10 | Converter output word |
| act_chan | output | 4 | Active channel selection |
| act_ref | output | 3 | Active reference selection |
| busy | output | 1 | Start pending or conversion in progress |
| sh_strobe | output | 1 | One-clock sample-and-hold strobe |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Captured conversion word |

## Verification
The completion of a conversion and a software flag clear can land on the same edge. The bench provokes this by holding `flag_clr` high through exactly the completion edge, which it computes from the start edge and the conversion length. It passes only if `done_flag` is still high afterwards, and a later clear must still drop it. A second overlap is a staging write made in the cycle right after a free-running completion, while the next conversion has already locked. The bench judges it by reading `act_chan` in the middle of each of the next two conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    K_FIRST = 2'd0,
    K_NORM  = 2'd1,
    K_AUTO  = 2'd2
  } conv_kind_e;

  typedef enum logic [1:0] {
    TS_NONE = 2'd0,
    TS_FREE = 2'd1,
    TS_EXT  = 2'd2,
    TS_RSVD = 2'd3
  } trig_src_e;
endpackage

// File: rtl/adc_sel_latch.sv
module adc_sel_latch #(
  parameter int CH_W  = 4,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [REF_W-1:0] wr_ref,
  input  logic             hold,
  output logic [CH_W-1:0]  act_chan,
  output logic [REF_W-1:0] act_ref
);
  logic [CH_W-1:0]  stg_chan;
  logic [REF_W-1:0] stg_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_chan <= '0;
      stg_ref  <= '0;
      act_chan <= '0;
      act_ref  <= '0;
    end else begin
      if (wr) begin
        stg_chan <= wr_chan;
        stg_ref  <= wr_ref;
      end
      // the active copy tracks the staging copy unless a conversion guards it
      if (!hold) begin
        act_chan <= stg_chan;
        act_ref  <= stg_ref;
      end
    end
  end
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       auto_en,
  input  logic [1:0] trig_sel,
  input  logic       start_wr,
  input  logic       trig_in,
  input  logic       run,
  input  logic       done_now,
  input  logic       done_first,
  output logic       go,
  output conv_kind_e go_kind,
  output logic       pend
);
  logic ph;       // 0: the coming edge is a rising converter edge
  logic trig_q;
  logic first_q;

  logic rise, ext_mode, free_mode, go_bit, go_trig, go_free, first_eff;

  assign rise      = trig_in & ~trig_q;
  assign ext_mode  = en && auto_en && (trig_sel == TS_EXT);
  assign free_mode = en && auto_en && (trig_sel == TS_FREE);
  assign go_bit    = pend && !ph && en;
  assign go_trig   = ext_mode && rise && !run && !pend;
  assign go_free   = free_mode && done_now;
  assign go        = go_bit | go_trig | go_free;
  assign first_eff = first_q && !done_first;

  always_comb begin
    if (first_eff)    go_kind = K_FIRST;
    else if (go_trig) go_kind = K_AUTO;
    else              go_kind = K_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      trig_q  <= 1'b0;
      first_q <= 1'b1;
      pend    <= 1'b0;
    end else begin
      ph     <= ~ph;
      trig_q <= trig_in;
      if (!en)             first_q <= 1'b1;
      else if (done_first) first_q <= 1'b0;
      if (!en)                      pend <= 1'b0;
      else if (go_bit)              pend <= 1'b0;
      else if (start_wr && !run)    pend <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int FIRST_LEN_H = 50,
  parameter int FIRST_SH_H  = 27,
  parameter int NORM_LEN_H  = 26,
  parameter int NORM_SH_H   = 3,
  parameter int AUTO_LEN_H  = 27,
  parameter int AUTO_SH_H   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       go,
  input  conv_kind_e go_kind,
  output logic       run,
  output logic       near_end,
  output logic       done_now,
  output logic       sh_strobe,
  output conv_kind_e cur_kind
);
  localparam int MAX_A = (FIRST_LEN_H > NORM_LEN_H) ? FIRST_LEN_H : NORM_LEN_H;
  localparam int MAX_L = (MAX_A > AUTO_LEN_H) ? MAX_A : AUTO_LEN_H;
  localparam int CW    = $clog2(MAX_L + 1);
  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t len_of(conv_kind_e k);
    case (k)
      K_FIRST: return cnt_t'(FIRST_LEN_H);
      K_AUTO:  return cnt_t'(AUTO_LEN_H);
      default: return cnt_t'(NORM_LEN_H);
    endcase
  endfunction

  function automatic cnt_t sh_of(conv_kind_e k);
    case (k)
      K_FIRST: return cnt_t'(FIRST_SH_H);
      K_AUTO:  return cnt_t'(AUTO_SH_H);
      default: return cnt_t'(NORM_SH_H);
    endcase
  endfunction

  cnt_t hc, len_c, sh_c;

  assign len_c    = len_of(cur_kind);
  assign sh_c     = sh_of(cur_kind);
  assign done_now = run && (hc == len_c - cnt_t'(1));
  assign near_end = run && (hc >= len_c - cnt_t'(2));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run       <= 1'b0;
      hc        <= '0;
      sh_strobe <= 1'b0;
      cur_kind  <= K_FIRST;
    end else begin
      sh_strobe <= run && ((hc + cnt_t'(1)) == sh_c);
      if (go) begin
        run      <= 1'b1;
        hc       <= '0;
        cur_kind <= go_kind;
      end else if (done_now) begin
        run <= 1'b0;
      end else if (run) begin
        hc <= hc + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int REF_W       = 3,
  parameter int RES_W       = 10,
  parameter int FIRST_LEN_H = 50,
  parameter int FIRST_SH_H  = 27,
  parameter int NORM_LEN_H  = 26,
  parameter int NORM_SH_H   = 3,
  parameter int AUTO_LEN_H  = 27,
  parameter int AUTO_SH_H   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             auto_en,
  input  logic [1:0]       trig_sel,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [REF_W-1:0] cfg_ref,
  input  logic             start_wr,
  input  logic             trig_in,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] conv_data,
  output logic [CH_W-1:0]  act_chan,
  output logic [REF_W-1:0] act_ref,
  output logic             busy,
  output logic             sh_strobe,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);
  logic       run_w, near_w, done_w, go_w, pend_w, hold_w, done_first_w;
  conv_kind_e go_kind_w, cur_kind_w;

  assign done_first_w = done_w && (cur_kind_w == K_FIRST);
  assign hold_w       = en && run_w && !near_w;
  assign busy         = run_w | pend_w;

  adc_sel_latch #(.CH_W(CH_W), .REF_W(REF_W)) u_sel (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_chan(cfg_chan), .wr_ref(cfg_ref),
    .hold(hold_w), .act_chan(act_chan), .act_ref(act_ref)
  );

  adc_start_ctl u_start (
    .clk(clk), .rst(rst), .en(en), .auto_en(auto_en), .trig_sel(trig_sel),
    .start_wr(start_wr), .trig_in(trig_in), .run(run_w), .done_now(done_w),
    .done_first(done_first_w), .go(go_w), .go_kind(go_kind_w), .pend(pend_w)
  );

  adc_conv_timer #(
    .FIRST_LEN_H(FIRST_LEN_H), .FIRST_SH_H(FIRST_SH_H),
    .NORM_LEN_H(NORM_LEN_H),   .NORM_SH_H(NORM_SH_H),
    .AUTO_LEN_H(AUTO_LEN_H),   .AUTO_SH_H(AUTO_SH_H)
  ) u_tmr (
    .clk(clk), .rst(rst), .abort(!en), .go(go_w), .go_kind(go_kind_w),
    .run(run_w), .near_end(near_w), .done_now(done_w),
    .sh_strobe(sh_strobe), .cur_kind(cur_kind_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      if (done_w)        done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
      if (done_w)        result <= conv_data;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W  = 4,
  parameter int REF_W = 3,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             flag_clr,
  input logic [RES_W-1:0] conv_data,
  input logic [CH_W-1:0]  act_chan,
  input logic [REF_W-1:0] act_ref,
  input logic             busy,
  input logic             sh_strobe,
  input logic             done_flag,
  input logic [RES_W-1:0] result,
  input logic             run,
  input logic             near_end,
  input logic             done_now
);
  p_sel_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(run) && !$past(near_end)) |-> ($stable(act_chan) && $stable(act_ref)));

  p_busy_drop_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done_flag || !$past(en)));

  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |-> busy);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    $past(done_now) |-> done_flag);

  p_flag_keep_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(done_flag) && !$past(flag_clr)) |-> done_flag);

  p_result_load_r10: assert property (@(posedge clk) disable iff (rst)
    $past(done_now) |-> (result == $past(conv_data)));

  p_result_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(done_now) |-> $stable(result));
endmodule

bind adc_seq_top adc_seq_chk #(.CH_W(CH_W), .REF_W(REF_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .flag_clr(flag_clr), .conv_data(conv_data),
  .act_chan(act_chan), .act_ref(act_ref), .busy(busy), .sh_strobe(sh_strobe),
  .done_flag(done_flag), .result(result), .run(run_w), .near_end(near_w),
  .done_now(done_w)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, auto_en = 1'b0, cfg_wr = 1'b0, start_wr = 1'b0;
  logic       trig_in = 1'b0, flag_clr = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [3:0] cfg_chan = '0;
  logic [2:0] cfg_ref = '0;
  logic [9:0] conv_data = '0;
  logic [3:0] act_chan;
  logic [2:0] act_ref;
  logic       busy, sh_strobe, done_flag;
  logic [9:0] result;

  int n_vec = 0, n_bad = 0, edge_n = 0;
  bit ended = 0;

  always #4 clk = ~clk;
  always @(posedge clk) edge_n <= rst ? 0 : edge_n + 1;

  adc_seq_top u0 (
    .clk(clk), .rst(rst), .en(en), .auto_en(auto_en), .trig_sel(trig_sel),
    .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .cfg_ref(cfg_ref), .start_wr(start_wr),
    .trig_in(trig_in), .flag_clr(flag_clr), .conv_data(conv_data),
    .act_chan(act_chan), .act_ref(act_ref), .busy(busy), .sh_strobe(sh_strobe),
    .done_flag(done_flag), .result(result)
  );

  // how(2) chan(4) data(10) len(6) sh(6); how 0 = start strobe, 1 = trigger
  localparam logic [27:0] VEC [6] = '{
    {2'd0, 4'd3,  10'h155, 6'd50, 6'd27},
    {2'd0, 4'd9,  10'h2AA, 6'd26, 6'd3},
    {2'd1, 4'd5,  10'h0F0, 6'd27, 6'd4},
    {2'd1, 4'd12, 10'h3FF, 6'd27, 6'd4},
    {2'd0, 4'd0,  10'h001, 6'd26, 6'd3},
    {2'd0, 4'd15, 10'h200, 6'd26, 6'd3}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_eq(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(int idx);
    for (int k = 0; k < 400 && edge_n < idx; k++) tick();
  endtask

  task automatic write_cfg(logic [3:0] c, logic [2:0] r);
    cfg_chan = c; cfg_ref = r; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  task automatic launch_bit(output int t);
    int e;
    e = edge_n;
    start_wr = 1'b1;
    tick();
    start_wr = 1'b0;
    t = (e % 2 == 0) ? e + 2 : e + 1;
  endtask

  task automatic launch_trig(output int t);
    t = edge_n;
    trig_in = 1'b1;
    tick();
    trig_in = 1'b0;
  endtask

  task automatic measure(output int sh_at, output int fl_at);
    sh_at = -1; fl_at = -1;
    for (int k = 0; k < 200; k++) begin
      if (sh_strobe && sh_at < 0) sh_at = edge_n - 1;
      if (done_flag) begin fl_at = edge_n - 1; break; end
      tick();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int t, sh_at, fl_at, chg;
    repeat (3) tick();
    // R1 reset state
    expect_eq("R1 busy", busy, 0);
    expect_eq("R1 flag", done_flag, 0);
    expect_eq("R1 strobe", sh_strobe, 0);
    expect_eq("R1 result", result, 0);
    expect_eq("R1 act_chan", act_chan, 0);
    expect_eq("R1 act_ref", act_ref, 0);
    rst = 1'b0;
    tick();
    en = 1'b1;

    // R2 idle following takes one edge after the staging write
    write_cfg(4'd7, 3'd2);
    expect_eq("R2 act lags", act_chan, 0);
    tick();
    expect_eq("R2 act_chan", act_chan, 7);
    expect_eq("R2 act_ref", act_ref, 2);

    // vector table: R4 R5 R6 R7 R9 R10
    auto_en = 1'b1; trig_sel = 2'b10;
    for (int i = 0; i < 6; i++) begin
      write_cfg(VEC[i][25:22], 3'd1);
      conv_data = VEC[i][21:12];
      tick();
      if (VEC[i][27:26] == 2'd0) launch_bit(t); else launch_trig(t);
      expect_eq("R4 busy during", busy, 1);
      measure(sh_at, fl_at);
      expect_eq("R5 R6 R7 strobe edge", sh_at, t + int'(VEC[i][5:0]));
      expect_eq("R5 R6 R7 R9 completion edge", fl_at, t + int'(VEC[i][11:6]));
      expect_eq("R10 result", result, int'(VEC[i][21:12]));
      expect_eq("R2 act_chan", act_chan, int'(VEC[i][25:22]));
      expect_eq("R4 busy cleared", busy, 0);
      pulse_clr();
      expect_eq("R9 clear", done_flag, 0);
    end

    // R3 selection frozen until edge T+L-1
    write_cfg(4'd4, 3'd0);
    tick();
    launch_bit(t);
    wait_edge(t + 5);
    write_cfg(4'd11, 3'd5);
    chg = -1;
    for (int k = 0; k < 60 && !done_flag; k++) begin
      if (act_chan == 4'd11 && chg < 0) chg = edge_n - 1;
      tick();
    end
    if (act_chan == 4'd11 && chg < 0) chg = edge_n - 1;
    expect_eq("R3 release edge", chg, t + 25);
    pulse_clr();

    // R7 trigger while busy ignored
    launch_trig(t);
    wait_edge(t + 10);
    trig_in = 1'b1; tick(); trig_in = 1'b0;
    measure(sh_at, fl_at);
    expect_eq("R7 completion unchanged", fl_at, t + 27);
    tick();
    expect_eq("R7 no retrigger busy", busy, 0);
    repeat (30) tick();
    expect_eq("R7 still idle", busy, 0);
    pulse_clr();

    // R9 set wins over clear on the completion edge
    conv_data = 10'h0AB;
    launch_bit(t);
    wait_edge(t + 26);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    expect_eq("R9 set beats clear", done_flag, 1);
    expect_eq("R10 result race", result, 10'h0AB);
    pulse_clr();
    expect_eq("R9 later clear", done_flag, 0);

    // R8 free running
    trig_sel = 2'b01;
    write_cfg(4'd2, 3'd0);
    tick();
    launch_bit(t);
    measure(sh_at, fl_at);
    expect_eq("R8 first completion", fl_at, t + 26);
    write_cfg(4'd6, 3'd0);
    pulse_clr();
    wait_edge(t + 37);
    expect_eq("R8 busy continues", busy, 1);
    expect_eq("R8 next uses old chan", act_chan, 2);
    measure(sh_at, fl_at);
    expect_eq("R8 second completion", fl_at, t + 52);
    pulse_clr();
    wait_edge(t + 63);
    expect_eq("R8 after next uses new chan", act_chan, 6);
    auto_en = 1'b0;
    measure(sh_at, fl_at);
    expect_eq("R8 third completion", fl_at, t + 78);
    tick();
    expect_eq("R8 stops", busy, 0);
    pulse_clr();

    // R11 abort and re-arm of the first conversion
    launch_bit(t);
    wait_edge(t + 8);
    en = 1'b0; tick();
    expect_eq("R11 abort busy", busy, 0);
    write_cfg(4'd13, 3'd3);
    tick();
    expect_eq("R11 unlocked", act_chan, 13);
    en = 1'b1; tick();
    launch_bit(t);
    measure(sh_at, fl_at);
    expect_eq("R11 first strobe", sh_at, t + 27);
    expect_eq("R11 first length", fl_at, t + 50);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule